// File: doc/BRIEF.md
# Execute-Disable Page Permission Checker

This block judges each memory access against the permission bits of the page it was translated to. The access type is a fetch, a read or a write. The block also takes the privilege of the access, the page's user, writable and no-execute bits, and the paging mode in force. From these it raises a page-fault flag and a two-bit reason code in the same cycle. The user and writable checks always apply. The no-execute check applies only to instruction fetches, only in the two wide paging modes, and only while software has switched it on.

The switch sits in a 64-bit extended-feature control register, which lives in the block and has a single-cycle write port. Two capability straps control this register. One says whether the register exists at all. The other says whether the no-execute feature is built in. A write that the hardware cannot honour is refused with a general-protection fault flag, and the stored value stays as it was. The long-mode-active bit in the readback shows a mode input and cannot be written. The register clears to zero on reset.

Top module: `xd_page_guard`

## Requirements
- R1: With bit 11 of the register at 1 and `pg_mode` 1 or 2, a fetch (`acc_kind` 0) from a page with `pg_nox`=1 faults with reason 3. A read (`acc_kind` 1) or a write (`acc_kind` 2) to such a page raises no no-execute fault.
- R2: With `pg_mode` 0 (legacy 32-bit paging) or 3 (treated the same way), `pg_nox` is ignored and reason 3 never appears.
- R3: While bit 11 of the register is 0, reason 3 never appears, whatever the page bits and the mode.
- R4: A user access (`acc_user`=1) to a supervisor page (`pg_user`=0) faults with reason 1, whatever the feature enable is. This fault takes priority over every other reason.
- R5: A write to a page with `pg_writable`=0 faults with reason 2, for either privilege (default `SUP_WP`=1). Reason 2 takes priority over reason 3.
- R6: `pf` is 1 exactly when `pf_reason` is nonzero. Reason 0 means the access is allowed. Fault outputs are combinational from the access inputs.
- R7: A write with bit 11 set while `cap_xd`=0 raises `gp` in that cycle and leaves the register unchanged.
- R8: A write that sets any reserved bit (bits 7:1, bit 9, bits 63:12) raises `gp` and leaves the register unchanged.
- R9: While `cap_reg`=0, every write raises `gp` and `rd_data` reads 0.
- R10: An accepted write stores bits 0, 8 and 11 at the next clock edge. Bit 10 of `rd_data` shows `lm_active`, and writing bit 10 is ignored without a fault.
- R11: Reset clears all stored register bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 2 | Access type: 0 fetch, 1 read, 2 write |
| acc_user | input | 1 | 1 when the access runs at user privilege |
| pg_user | input | 1 | Page allows user access |
| pg_writable | input | 1 | Page allows writes |
| pg_nox | input | 1 | Page forbids instruction fetch |
| pg_mode | input | 2 | Paging mode: 0 legacy, 1 PAE, 2 long, 3 treated as legacy |
| cap_reg | input | 1 | Strap: control register present |
| cap_xd | input | 1 | Strap: no-execute feature present |
| lm_active | input | 1 | Long-mode active status shown on bit 10 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| pf | output | 1 | Page fault |
| pf_reason | output | 2 | 0 none, 1 privilege, 2 write protect, 3 no-execute |
| gp | output | 1 | General-protection fault for a refused write |
| rd_data | output | 64 | Register readback |

## Verification
The access check and the register write can both happen in one cycle. In that cycle the fault outputs must still follow the old enable bit, and the new value takes over only from the next cycle. The bench writes the register and presents a no-execute fetch in the same cycle. It expects the fault reason from the previous register state, then checks the readback and the fault reason on the next cycle. Refused writes are paired with accesses in the same way, so the bench can see that the gp fault leaves the fault path unchanged.

// File: rtl/xd_pkg.sv
package xd_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      PGM_LEGACY = 2'd0,
      PGM_PAE    = 2'd1,
      PGM_LONG   = 2'd2,
      PGM_OFF    = 2'd3
   } pg_mode_e;

   typedef enum logic [1:0] {
      WHY_NONE  = 2'd0,
      WHY_PRIV  = 2'd1,
      WHY_WPROT = 2'd2,
      WHY_NOX   = 2'd3
   } fault_why_e;

   function automatic logic mode_has_nox(input pg_mode_e m);
      return (m == PGM_PAE) || (m == PGM_LONG);
   endfunction
endpackage

// File: rtl/xd_ctrl_reg.sv
module xd_ctrl_reg #(
   parameter int REG_W   = 64,
   parameter int SCE_BIT = 0,
   parameter int LME_BIT = 8,
   parameter int LMA_BIT = 10,
   parameter int NXE_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_reg,
   input  logic             cap_xd,
   input  logic             lm_active,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             gp,
   output logic [REG_W-1:0] rd_data,
   output logic             nxe_on
);
   localparam logic [REG_W-1:0] ONE      = {{(REG_W-1){1'b0}}, 1'b1};
   localparam logic [REG_W-1:0] WR_MASK  = (ONE << SCE_BIT) | (ONE << LME_BIT) | (ONE << NXE_BIT);
   localparam logic [REG_W-1:0] RO_MASK  = ONE << LMA_BIT;
   localparam logic [REG_W-1:0] RSV_MASK = ~(WR_MASK | RO_MASK);

   if (REG_W < 12) begin : g_bad_width
      $error("xd_ctrl_reg: REG_W must hold every defined bit");
   end
   if (SCE_BIT == LME_BIT || LME_BIT == LMA_BIT || LMA_BIT == NXE_BIT ||
       SCE_BIT == NXE_BIT || SCE_BIT == LMA_BIT || LME_BIT == NXE_BIT) begin : g_bad_bits
      $error("xd_ctrl_reg: field positions must be distinct");
   end

   logic             rsv_hit;
   logic             nxe_refused;
   logic             accept;
   logic [REG_W-1:0] view;

   assign rsv_hit     = |(wr_data & RSV_MASK);
   assign nxe_refused = wr_data[NXE_BIT] & ~cap_xd;
   assign gp          = wr_en & (~cap_reg | rsv_hit | nxe_refused);
   assign accept      = wr_en & ~gp;

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_store
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (accept) q <= wr_data[b];
         end
         assign view[b] = q;
      end else if (b == LMA_BIT) begin : g_status
         assign view[b] = lm_active;
      end else begin : g_zero
         assign view[b] = 1'b0;
      end
   end

   assign rd_data = cap_reg ? view : '0;
   assign nxe_on  = view[NXE_BIT];
endmodule

// File: rtl/xd_perm_check.sv
module xd_perm_check
   import xd_pkg::*;
#(
   parameter bit SUP_WP = 1'b1
) (
   input  logic [1:0] acc_kind,
   input  logic       acc_user,
   input  logic       pg_user,
   input  logic       pg_writable,
   input  logic       pg_nox,
   input  logic [1:0] pg_mode,
   input  logic       nxe_on,
   output logic       fault,
   output logic [1:0] reason
);
   acc_kind_e  kind;
   pg_mode_e   mode;
   logic       priv_hit;
   logic       wp_hit;
   logic       nox_hit;
   fault_why_e why;

   assign kind     = acc_kind_e'(acc_kind);
   assign mode     = pg_mode_e'(pg_mode);
   assign priv_hit = acc_user & ~pg_user;
   assign nox_hit  = (kind == ACC_FETCH) & pg_nox & nxe_on & mode_has_nox(mode);

   if (SUP_WP) begin : g_wp_all
      assign wp_hit = (kind == ACC_WRITE) & ~pg_writable;
   end else begin : g_wp_user
      assign wp_hit = (kind == ACC_WRITE) & ~pg_writable & acc_user;
   end

   always_comb begin
      why = WHY_NONE;
      if (priv_hit)     why = WHY_PRIV;
      else if (wp_hit)  why = WHY_WPROT;
      else if (nox_hit) why = WHY_NOX;
   end

   assign reason = why;
   assign fault  = (why != WHY_NONE);
endmodule

// File: rtl/xd_page_guard.sv
module xd_page_guard #(
   parameter int REG_W   = 64,
   parameter int SCE_BIT = 0,
   parameter int LME_BIT = 8,
   parameter int LMA_BIT = 10,
   parameter int NXE_BIT = 11,
   parameter bit SUP_WP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       acc_kind,
   input  logic             acc_user,
   input  logic             pg_user,
   input  logic             pg_writable,
   input  logic             pg_nox,
   input  logic [1:0]       pg_mode,
   input  logic             cap_reg,
   input  logic             cap_xd,
   input  logic             lm_active,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             pf,
   output logic [1:0]       pf_reason,
   output logic             gp,
   output logic [REG_W-1:0] rd_data
);
   logic nxe_on;

   xd_ctrl_reg #(
      .REG_W(REG_W), .SCE_BIT(SCE_BIT), .LME_BIT(LME_BIT),
      .LMA_BIT(LMA_BIT), .NXE_BIT(NXE_BIT)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .cap_reg(cap_reg), .cap_xd(cap_xd),
      .lm_active(lm_active), .wr_en(wr_en), .wr_data(wr_data),
      .gp(gp), .rd_data(rd_data), .nxe_on(nxe_on)
   );

   xd_perm_check #(.SUP_WP(SUP_WP)) u_chk_perm (
      .acc_kind(acc_kind), .acc_user(acc_user), .pg_user(pg_user),
      .pg_writable(pg_writable), .pg_nox(pg_nox), .pg_mode(pg_mode),
      .nxe_on(nxe_on), .fault(pf), .reason(pf_reason)
   );
endmodule

// File: rtl/xd_page_guard_chk.sv
module xd_page_guard_chk #(
   parameter int REG_W   = 64,
   parameter int LMA_BIT = 10,
   parameter int NXE_BIT = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       acc_kind,
   input logic             acc_user,
   input logic             pg_user,
   input logic [1:0]       pg_mode,
   input logic             cap_reg,
   input logic             cap_xd,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic             pf,
   input logic [1:0]       pf_reason,
   input logic             gp,
   input logic [REG_W-1:0] rd_data,
   input logic             nxe_on
);
   localparam logic [REG_W-1:0] KEEP = ~({{(REG_W-1){1'b0}}, 1'b1} << LMA_BIT);

   p_nox_fetch_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind != 2'd0) |-> (pf_reason != 2'd3));

   p_legacy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_mode == 2'd0 || pg_mode == 2'd3) |-> (pf_reason != 2'd3));

   p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !nxe_on |-> (pf_reason != 2'd3));

   p_priv_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_user && !pg_user) |-> (pf && pf_reason == 2'd1));

   p_nox_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[NXE_BIT] && !cap_xd) |-> gp);

   p_refused_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && gp && cap_reg) |=> (!cap_reg || ((rd_data & KEEP) == $past(rd_data & KEEP))));

   p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_reg |-> (rd_data == '0 && (!wr_en || gp)));

   p_accept_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !gp) |=> (nxe_on == $past(wr_data[NXE_BIT])));
endmodule

bind xd_page_guard xd_page_guard_chk #(
   .REG_W(REG_W), .LMA_BIT(LMA_BIT), .NXE_BIT(NXE_BIT)
) u_guard_chk (
   .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_user(acc_user),
   .pg_user(pg_user), .pg_mode(pg_mode), .cap_reg(cap_reg), .cap_xd(cap_xd),
   .wr_en(wr_en), .wr_data(wr_data), .pf(pf), .pf_reason(pf_reason),
   .gp(gp), .rd_data(rd_data), .nxe_on(nxe_on)
);

// File: tb/xd_page_guard_bench.sv
module xd_page_guard_bench;
   localparam logic [63:0] B_SCE = 64'h1;
   localparam logic [63:0] B_LME = 64'h100;
   localparam logic [63:0] B_LMA = 64'h400;
   localparam logic [63:0] B_NXE = 64'h800;
   localparam logic [63:0] WMASK = B_SCE | B_LME | B_NXE;
   localparam logic [63:0] RSV   = ~(WMASK | B_LMA);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  acc_kind = 2'd1;
   logic        acc_user = 1'b0, pg_user = 1'b1, pg_writable = 1'b1, pg_nox = 1'b0;
   logic [1:0]  pg_mode = 2'd0;
   logic        cap_reg = 1'b1, cap_xd = 1'b1, lm_active = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        pf, gp;
   logic [1:0]  pf_reason;
   logic [63:0] rd_data;

   typedef struct {
      string       tag;
      logic        pf;
      logic [1:0]  why;
      logic        gp;
      logic [63:0] rd;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   logic [63:0] m_reg = '0;
   bit          done = 0;

   always #5 clk = ~clk;

   xd_page_guard u_xd_page_guard (
      .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_user(acc_user),
      .pg_user(pg_user), .pg_writable(pg_writable), .pg_nox(pg_nox),
      .pg_mode(pg_mode), .cap_reg(cap_reg), .cap_xd(cap_xd),
      .lm_active(lm_active), .wr_en(wr_en), .wr_data(wr_data),
      .pf(pf), .pf_reason(pf_reason), .gp(gp), .rd_data(rd_data)
   );

   function automatic logic [1:0] model_why();
      if (acc_user && !pg_user) return 2'd1;
      if (acc_kind == 2'd2 && !pg_writable) return 2'd2;
      if (acc_kind == 2'd0 && pg_nox && m_reg[11] && (pg_mode == 2'd1 || pg_mode == 2'd2))
         return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic model_gp();
      return wr_en && (!cap_reg || ((wr_data & RSV) != 0) || (wr_data[11] && !cap_xd));
   endfunction

   task automatic set_acc(input logic [1:0] k, input logic u, input logic pu,
                          input logic pw, input logic nx, input logic [1:0] m);
      acc_kind = k; acc_user = u; pg_user = pu; pg_writable = pw; pg_nox = nx; pg_mode = m;
   endtask

   task automatic step(input string tag);
      exp_t e;
      logic g;
      e.tag = tag;
      e.why = model_why();
      e.pf  = (e.why != 2'd0);
      g     = model_gp();
      e.gp  = g;
      e.rd  = cap_reg ? (m_reg | (lm_active ? B_LMA : 64'h0)) : 64'h0;
      sb.push_back(e);
      @(posedge clk);
      #1;
      if (wr_en && !g) m_reg = wr_data & WMASK;
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (pf !== e.pf || pf_reason !== e.why || gp !== e.gp || rd_data !== e.rd) begin
            errors++;
            $display("FAIL %s: got pf=%0b why=%0d gp=%0b rd=%h, expected pf=%0b why=%0d gp=%0b rd=%h",
                     e.tag, pf, pf_reason, gp, rd_data, e.pf, e.why, e.gp, e.rd);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #2;
      checks++;
      if (rd_data !== 64'h0) begin
         errors++;
         $display("FAIL R11 reset: got %h expected 0", rd_data);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R3: feature off, no-execute fetch in long mode is allowed
      set_acc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2); step("R3 off");
      // R10 write together with fetch: old enable still rules this cycle
      wr_en = 1'b1; wr_data = B_SCE | B_LME | B_NXE; step("R10 write");
      lm_active = 1'b1;
      // R1 fetch now faults; readback shows stored bits and status bit
      step("R1 long fetch");
      set_acc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1); step("R1 pae fetch");
      set_acc(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2); step("R1 read ok");
      set_acc(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2); step("R1 write ok");
      set_acc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0); step("R2 legacy");
      set_acc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3); step("R2 mode3");
      set_acc(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2); step("R4 priv over nox");
      set_acc(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1); step("R4 priv over wp");
      set_acc(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2); step("R5 sup write");
      set_acc(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0); step("R5 user write");
      set_acc(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2); step("R6 clean read");
      // R8 reserved bit 9 refused, then contents unchanged
      set_acc(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2);
      wr_en = 1'b1; wr_data = 64'h200; step("R8 rsv9");
      wr_en = 1'b1; wr_data = 64'h1_0000_0000; step("R8 rsv high");
      step("R8 hold");
      // R10 bit 10 ignored, other stored bits cleared
      wr_en = 1'b1; wr_data = B_LMA; step("R10 ro bit");
      step("R3 cleared");
      lm_active = 1'b0;
      // R7 feature absent
      cap_xd = 1'b0;
      wr_en = 1'b1; wr_data = B_NXE | B_SCE; step("R7 refused");
      step("R7 hold");
      wr_en = 1'b1; wr_data = B_LME; step("R7 other ok");
      step("R7 lme stored");
      // R9 register absent
      cap_reg = 1'b0;
      wr_en = 1'b1; wr_data = B_SCE; step("R9 absent write");
      step("R9 absent read");
      cap_reg = 1'b1; cap_xd = 1'b1;
      step("R9 back");
      wr_en = 1'b1; wr_data = WMASK; step("R11 prep");
      step("R11 set");
      rst_n = 1'b0; m_reg = '0;
      step("R11 cleared");
      rst_n = 1'b1;
      step("R11 after");
      repeat (2) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule